// File: doc/BRIEF.md
# Receiver Enable Training Sequencer

This block runs one pass of hardware-assisted receive-enable training for a single rank of a DDR channel. Once a start request is accepted, it latches the DIMM index that belongs to the requested chip select and asks the seed logic to prepare the per-lane starting delays. It then raises the PHY training enable. With the enable high, it issues a short burst of back-to-back reads to a fixed test address, so that the strobe toggles continuously while the PHY locks on to its edges. After a fixed settling interval it drops the enable again.

In the last phase the sequencer walks the byte lanes in ascending order. For each lane it reads the phase value that the PHY measured and the coarse offset saved during seeding. It writes back the sum of the low eight bits of the phase, the offset bits that carry whole-UI steps, and one UI, which places the receive enable at the middle of the read preamble. While it walks the lanes it keeps the largest result and presents it with a one-cycle done pulse, for use in setting the maximum read latency.

The surrounding firmware or controller must switch off automatic refresh and ZQ calibration before training starts. A qualifying input reports this condition, and a start request is refused while that input is low.

Top module: `rxen_train_seq`

## Requirements
- R1: A start request is accepted only in the idle state with `quiet_ok_i` high. A start seen while `quiet_ok_i` is low leaves the block idle: `busy_o`, `seed_go_o` and `rd_req_o` stay low.
- R2: In the cycle after an accepted start, `busy_o` is high and `dimm_sel_o` equals `chip_sel_i` shifted right by one bit. That value is held until done.
- R3: `seed_go_o` stays high until `seed_done_i` is seen. `train_en_o` rises only after that handshake.
- R4: `train_en_o` is high for at least one cycle before the first read request is raised.
- R5: Exactly 3 read requests are accepted per pass. Each carries address 0x200000 (1 << 21) and length 64 bytes, and each is held until `rd_ack_i` is sampled high with it.
- R6: After the cycle in which the third read is accepted, `train_en_o` stays high for exactly 200 cycles and then falls.
- R7: Once the enable has dropped, lanes 0 to 7 are processed in order. `dly_rd_o` is asserted with `dly_lane_o` for one cycle. In the next cycle `dly_wr_o` is asserted for the same lane, and `dly_wdata_o` = `ph_dly_i`[7:0] + (`seed_ofs_i` & 0x1E0) + 0x20, with both inputs taken in that write cycle. The upper phase bits and the offset bits outside 0x1E0 have no effect.
- R8: When `done_o` is high, `max_dly_o` equals the largest of the eight values written in that pass.
- R9: `done_o` is a single-cycle pulse. In the following cycle the block is idle again, with `busy_o` low.
- R10: A start request seen while the block is busy is ignored. The current pass runs to completion with its own DIMM selection and produces exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to run a training pass |
| quiet_ok_i | input | 1 | High when refresh and ZQ calibration are off |
| chip_sel_i | input | 3 | Chip select of the rank to train |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dimm_sel_o | output | 3 | DIMM index under training (chip select >> 1) |
| seed_go_o | output | 1 | Request to the seed logic |
| seed_done_i | input | 1 | Seed logic finished |
| train_en_o | output | 1 | PHY receive-enable training enable |
| rd_req_o | output | 1 | Read request to the controller |
| rd_addr_o | output | 32 | Read address |
| rd_len_o | output | 8 | Read length in bytes |
| rd_ack_i | input | 1 | Controller accepts the read request |
| dly_lane_o | output | 3 | Lane addressed on the delay port |
| dly_rd_o | output | 1 | Read the lane's phase and saved offset |
| dly_wr_o | output | 1 | Write the lane's final receive-enable delay |
| dly_wdata_o | output | 10 | Final delay value being written |
| ph_dly_i | input | 10 | Measured phase delay, valid the cycle after a read |
| seed_ofs_i | input | 10 | Saved coarse offset, valid the cycle after a read |
| max_dly_o | output | 10 | Largest final delay of the pass |

## Verification
The bench varies the acknowledge latency on reads and on seeding, including zero-wait acknowledges. A design that drops a request early, or miscounts the reads that were accepted, ends up with the wrong read count or a settling window shifted by the acknowledge delay. Lane data sets mix all-zero lanes (minimum 0x20), all-ones lanes that reach the 0x2FF ceiling, a single large lane at lane 0, and random values with garbage in the ignored bits. These catch a design that uses the wrong mask or omits the UI step, and a running maximum that never moves past its first lane or resets at the wrong time. The phase inputs are scrambled outside the valid cycle, so sampling them one cycle off gives wrong write data. Starts that arrive while the quiet condition is false, or while a pass is running, must leave no trace at the ports.

// File: rtl/rxen_pkg.sv
// Package: shared types and fixed encodings of the receive-enable
// training sequencer.
// Assumes: nothing; imported by the top module only.
package rxen_pkg;

    // Top-level sequence phases, in the order they are visited.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SELECT = 3'd1,
        ST_SEED   = 3'd2,
        ST_ARM    = 3'd3,
        ST_READS  = 3'd4,
        ST_SETTLE = 3'd5,
        ST_CALC   = 3'd6,
        ST_FINISH = 3'd7
    } seq_state_t;

endpackage

// File: rtl/rxen_burst.sv
// Module: rxen_burst
// Issues NUM_RD read requests to a fixed address, one after another.
// Each request is held until the controller acknowledges it.
// last_o marks the cycle in which the final request is accepted.
// Assumes: go_i is a single-cycle pulse given only while no burst is
// running.
module rxen_burst #(
    parameter int                NUM_RD    = 3,
    parameter int                ADDR_W    = 32,
    parameter int                LEN_W     = 8,
    parameter logic [ADDR_W-1:0] TEST_ADDR = 32'h0020_0000,
    parameter int                RD_BYTES  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              rd_ack_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [LEN_W-1:0]  rd_len_o,
    output logic              last_o
);
    localparam int CNT_W = $clog2(NUM_RD + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_RD - 1);

    logic             req_q;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    assign accept    = req_q && rd_ack_i;
    assign last_o    = accept && (cnt_q == LAST_IDX);
    assign rd_req_o  = req_q;
    assign rd_addr_o = TEST_ADDR;
    assign rd_len_o  = LEN_W'(RD_BYTES);

    // Purpose: raise the request on go, count accepted reads, drop after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            cnt_q <= '0;
        end else if (go_i) begin
            req_q <= 1'b1;
            cnt_q <= '0;
        end else if (accept) begin
            if (cnt_q == LAST_IDX) begin
                req_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R5: a request that was not acknowledged is still there in the next cycle
    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i && !go_i) |=> rd_req_o);

    // R5: the accepted-read count never reaches the burst length
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(NUM_RD));

    // R5: after the final accept the request line is released
    assert_release_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !go_i) |=> !rd_req_o);
endmodule

// File: rtl/rxen_settle.sv
// Module: rxen_settle
// Counts a fixed settling window of WAIT_CYC cycles. expire_o is high
// in the last cycle of the window.
// Assumes: go_i is a single-cycle pulse; WAIT_CYC >= 1.
module rxen_settle #(
    parameter int WAIT_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic run_o,
    output logic expire_o
);
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] END_CNT = CNT_W'(WAIT_CYC - 1);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    assign run_o    = run_q;
    assign expire_o = run_q && (cnt_q == END_CNT);

    // Purpose: start on go, advance each cycle, stop at the end of the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (go_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (expire_o) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the counter stays inside the window
    assert_cnt_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= END_CNT);

    // R6: the window closes right after it expires
    assert_stop_after_expire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !go_i) |=> !run_o);
endmodule

// File: rtl/rxen_lane_calc.sv
// Module: rxen_lane_calc
// Walks the lanes in ascending order. For each lane it asserts one read
// cycle, then one write cycle that carries
// phase[PH_W-1:0] + (offset & whole-UI mask) + one UI.
// It keeps the largest value written since go.
// Assumes: phase and offset inputs are valid in the cycle after dly_rd_o.
module rxen_lane_calc #(
    parameter int LANES   = 8,
    parameter int DLY_W   = 10,
    parameter int PH_W    = 8,
    parameter int UI_LOG2 = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go_i,
    input  logic [DLY_W-1:0]         ph_dly_i,
    input  logic [DLY_W-1:0]         seed_ofs_i,
    output logic [$clog2(LANES)-1:0] lane_o,
    output logic                     dly_rd_o,
    output logic                     dly_wr_o,
    output logic [DLY_W-1:0]         dly_wdata_o,
    output logic [DLY_W-1:0]         max_dly_o,
    output logic                     fin_o
);
    localparam int LANE_W = $clog2(LANES);
    localparam logic [DLY_W-1:0] PH_MASK  = DLY_W'((1 << PH_W) - 1);
    localparam logic [DLY_W-1:0] OFS_MASK = DLY_W'(((1 << (PH_W + 1)) - 1) & ~((1 << UI_LOG2) - 1));
    localparam logic [DLY_W-1:0] ONE_UI   = DLY_W'(1 << UI_LOG2);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    logic              active_q;
    logic              wr_phase_q;
    logic [LANE_W-1:0] lane_q;
    logic [DLY_W-1:0]  max_q;
    logic [DLY_W-1:0]  final_dly;

    // Purpose: form the lane's final delay from the values returned by the port.
    always_comb begin
        final_dly = (ph_dly_i & PH_MASK) + (seed_ofs_i & OFS_MASK) + ONE_UI;
    end

    assign lane_o      = lane_q;
    assign dly_rd_o    = active_q && !wr_phase_q;
    assign dly_wr_o    = active_q && wr_phase_q;
    assign dly_wdata_o = final_dly;
    assign max_dly_o   = max_q;
    assign fin_o       = dly_wr_o && (lane_q == LAST_LANE);

    // Purpose: alternate read and write cycles per lane, moving to the next lane after each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            wr_phase_q <= 1'b0;
            lane_q     <= '0;
        end else if (go_i) begin
            active_q   <= 1'b1;
            wr_phase_q <= 1'b0;
            lane_q     <= '0;
        end else if (active_q) begin
            wr_phase_q <= !wr_phase_q;
            if (wr_phase_q) begin
                if (lane_q == LAST_LANE) begin
                    active_q <= 1'b0;
                    lane_q   <= '0;
                end else begin
                    lane_q <= lane_q + 1'b1;
                end
            end
        end
    end

    // Purpose: running maximum of the written delays, cleared at the start of each pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q <= '0;
        end else if (go_i) begin
            max_q <= '0;
        end else if (dly_wr_o && (final_dly > max_q)) begin
            max_q <= final_dly;
        end
    end

    // R7: read and write on the delay port never overlap
    assert_rd_wr_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dly_rd_o && dly_wr_o));

    // R7: a write always follows a read of the same lane
    assert_wr_after_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dly_rd_o |=> (dly_wr_o && (lane_o == $past(lane_o))));

    // R7: every written delay includes at least one UI
    assert_wdata_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dly_wr_o |-> (dly_wdata_o >= ONE_UI));

    // R8: the running maximum covers the value just written
    assert_max_covers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_wr_o && !go_i) |=> (max_dly_o >= $past(dly_wdata_o)));
endmodule

// File: rtl/rxen_train_seq.sv
// Module: rxen_train_seq (top)
// Sequences one receive-enable training pass: DIMM select, seeding,
// enable on, read burst, settle, enable off, per-lane final delays.
// Ends with a one-cycle done pulse that carries the largest lane delay.
// Assumes: refresh and ZQ calibration are reported off on quiet_ok_i
// before start; the seed logic answers seed_go_o with seed_done_i.
module rxen_train_seq #(
    parameter int                CS_W      = 3,
    parameter int                ADDR_W    = 32,
    parameter int                LEN_W     = 8,
    parameter logic [ADDR_W-1:0] TEST_ADDR = 32'h0020_0000,
    parameter int                RD_BYTES  = 64,
    parameter int                NUM_RD    = 3,
    parameter int                WAIT_CYC  = 200,
    parameter int                LANES     = 8,
    parameter int                DLY_W     = 10,
    parameter int                PH_W      = 8,
    parameter int                UI_LOG2   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     quiet_ok_i,
    input  logic [CS_W-1:0]          chip_sel_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [CS_W-1:0]          dimm_sel_o,
    output logic                     seed_go_o,
    input  logic                     seed_done_i,
    output logic                     train_en_o,
    output logic                     rd_req_o,
    output logic [ADDR_W-1:0]        rd_addr_o,
    output logic [LEN_W-1:0]         rd_len_o,
    input  logic                     rd_ack_i,
    output logic [$clog2(LANES)-1:0] dly_lane_o,
    output logic                     dly_rd_o,
    output logic                     dly_wr_o,
    output logic [DLY_W-1:0]         dly_wdata_o,
    input  logic [DLY_W-1:0]         ph_dly_i,
    input  logic [DLY_W-1:0]         seed_ofs_i,
    output logic [DLY_W-1:0]         max_dly_o
);
    import rxen_pkg::*;

    seq_state_t      state_q, state_d;
    logic [CS_W-1:0] dimm_q;
    logic            train_en_q;
    logic            burst_go, burst_last;
    logic            settle_go, settle_run, settle_expire;
    logic            calc_go, calc_fin;
    logic            take_start;

    assign take_start = (state_q == ST_IDLE) && start_i && quiet_ok_i;
    assign burst_go   = (state_q == ST_ARM);
    assign settle_go  = (state_q == ST_READS) && burst_last;
    assign calc_go    = (state_q == ST_SETTLE) && settle_expire;

    // Purpose: next-phase selection of the training sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take_start)    state_d = ST_SELECT;
            ST_SELECT:                    state_d = ST_SEED;
            ST_SEED:   if (seed_done_i)   state_d = ST_ARM;
            ST_ARM:                       state_d = ST_READS;
            ST_READS:  if (burst_last)    state_d = ST_SETTLE;
            ST_SETTLE: if (settle_expire) state_d = ST_CALC;
            ST_CALC:   if (calc_fin)      state_d = ST_FINISH;
            ST_FINISH:                    state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // Purpose: sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: capture the DIMM index of the requested rank at start.
    always_ff @(posedge clk) begin
        if (!rst_n)          dimm_q <= '0;
        else if (take_start) dimm_q <= chip_sel_i >> 1;
    end

    // Purpose: training enable, on after seeding and off when settling ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   train_en_q <= 1'b0;
        else if ((state_q == ST_SEED) && seed_done_i) train_en_q <= 1'b1;
        else if (calc_go)                             train_en_q <= 1'b0;
    end

    rxen_burst #(
        .NUM_RD    (NUM_RD),
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .TEST_ADDR (TEST_ADDR),
        .RD_BYTES  (RD_BYTES)
    ) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (burst_go),
        .rd_ack_i  (rd_ack_i),
        .rd_req_o  (rd_req_o),
        .rd_addr_o (rd_addr_o),
        .rd_len_o  (rd_len_o),
        .last_o    (burst_last)
    );

    rxen_settle #(
        .WAIT_CYC  (WAIT_CYC)
    ) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (settle_go),
        .run_o     (settle_run),
        .expire_o  (settle_expire)
    );

    rxen_lane_calc #(
        .LANES       (LANES),
        .DLY_W       (DLY_W),
        .PH_W        (PH_W),
        .UI_LOG2     (UI_LOG2)
    ) u_calc (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (calc_go),
        .ph_dly_i    (ph_dly_i),
        .seed_ofs_i  (seed_ofs_i),
        .lane_o      (dly_lane_o),
        .dly_rd_o    (dly_rd_o),
        .dly_wr_o    (dly_wr_o),
        .dly_wdata_o (dly_wdata_o),
        .max_dly_o   (max_dly_o),
        .fin_o       (calc_fin)
    );

    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = (state_q == ST_FINISH);
    assign dimm_sel_o = dimm_q;
    assign seed_go_o  = (state_q == ST_SEED);
    assign train_en_o = train_en_q;

    // R1: a start without the quiet condition keeps the block idle
    assert_start_blocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !quiet_ok_i) |=> !busy_o);

    // R10: a start during a pass does not change the DIMM selection
    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> $stable(dimm_sel_o));

    // R3: the enable rises only after the seed handshake
    assert_seed_before_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en_o) |-> $past(seed_go_o && seed_done_i));

    // R6: the settling window runs only with the enable high
    assert_settle_with_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        settle_run |-> train_en_o);

    // R7: lane processing starts only after the enable is off
    assert_calc_enable_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_rd_o || dly_wr_o) |-> !train_en_o);

    // R9: done is a single-cycle pulse followed by idle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
endmodule

// File: tb/rxen_train_seq_tb.sv
module rxen_train_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        quiet_ok_i = 1'b0;
    logic [2:0]  chip_sel_i = '0;
    logic        busy_o, done_o, seed_go_o, train_en_o, rd_req_o;
    logic [2:0]  dimm_sel_o;
    logic        seed_done_i = 1'b0;
    logic [31:0] rd_addr_o;
    logic [7:0]  rd_len_o;
    logic        rd_ack_i = 1'b0;
    logic [2:0]  dly_lane_o;
    logic        dly_rd_o, dly_wr_o;
    logic [9:0]  dly_wdata_o, max_dly_o;
    logic [9:0]  ph_dly_i = '0;
    logic [9:0]  seed_ofs_i = '0;

    always #2 clk = ~clk;

    rxen_train_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .quiet_ok_i(quiet_ok_i),
        .chip_sel_i(chip_sel_i), .busy_o(busy_o), .done_o(done_o),
        .dimm_sel_o(dimm_sel_o), .seed_go_o(seed_go_o), .seed_done_i(seed_done_i),
        .train_en_o(train_en_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_len_o(rd_len_o), .rd_ack_i(rd_ack_i), .dly_lane_o(dly_lane_o),
        .dly_rd_o(dly_rd_o), .dly_wr_o(dly_wr_o), .dly_wdata_o(dly_wdata_o),
        .ph_dly_i(ph_dly_i), .seed_ofs_i(seed_ofs_i), .max_dly_o(max_dly_o)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    logic [9:0] ph_arr [8];
    logic [9:0] ofs_arr[8];
    int exp_max;

    // per-pass monitor state
    int rd_acc, en_cnt, lane_idx, done_cnt;
    bit en_armed, seed_seen, first_rd, prev_en, prev_req;
    int ack_wait, seed_wait;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_final(input logic [9:0] p, input logic [9:0] o);
        return int'(p & 10'h0FF) + int'(o & 10'h1E0) + 32'h20;
    endfunction

    // Watchdog: a hung run is a failure and still reaches the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Seed logic model with random latency.
    always @(posedge clk) begin
        if (!seed_go_o) begin
            seed_done_i <= 1'b0;
            seed_wait   <= $urandom_range(0, 5);
        end else if (seed_done_i) begin
            seed_done_i <= 1'b0;
        end else if (seed_wait == 0) begin
            seed_done_i <= 1'b1;
        end else begin
            seed_wait <= seed_wait - 1;
        end
    end

    // Memory-controller model: acknowledges reads after a random delay.
    always @(posedge clk) begin
        if (!rd_req_o || rd_ack_i) begin
            rd_ack_i <= 1'b0;
            ack_wait <= $urandom_range(0, 3);
        end else if (ack_wait == 0) begin
            rd_ack_i <= 1'b1;
        end else begin
            ack_wait <= ack_wait - 1;
        end
    end

    // Delay port model: data valid the cycle after a read, garbage otherwise.
    always @(posedge clk) begin
        if (dly_rd_o) begin
            ph_dly_i   <= ph_arr[dly_lane_o];
            seed_ofs_i <= ofs_arr[dly_lane_o];
        end else begin
            ph_dly_i   <= 10'($urandom);
            seed_ofs_i <= 10'($urandom);
        end
    end

    // Port monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (en_armed) begin
                if (train_en_o) en_cnt++;
                else en_armed = 1'b0;
            end
            if (seed_go_o && seed_done_i) seed_seen = 1'b1;
            if (train_en_o && !prev_en)
                chk(seed_seen, "R3 enable before seed done", 0, 1);
            if (rd_req_o && !prev_req && first_rd) begin
                chk(prev_en, "R4 enable ahead of first read", int'(prev_en), 1);
                first_rd = 1'b0;
            end
            if (rd_req_o && rd_ack_i) begin
                rd_acc++;
                chk(rd_addr_o == 32'h0020_0000, "R5 read address", int'(rd_addr_o), 32'h200000);
                chk(rd_len_o == 8'd64, "R5 read length", int'(rd_len_o), 64);
                if (rd_acc == 3) en_armed = 1'b1;
            end
            if (dly_wr_o) begin
                chk(int'(dly_lane_o) == lane_idx, "R7 lane order", int'(dly_lane_o), lane_idx);
                chk(int'(dly_wdata_o) == exp_final(ph_arr[lane_idx], ofs_arr[lane_idx]),
                    "R7 final delay", int'(dly_wdata_o), exp_final(ph_arr[lane_idx], ofs_arr[lane_idx]));
                lane_idx++;
            end
            if (done_o) begin
                done_cnt++;
                chk(int'(max_dly_o) == exp_max, "R8 max delay", int'(max_dly_o), exp_max);
                chk(rd_acc == 3, "R5 read count", rd_acc, 3);
                chk(en_cnt == 200, "R6 enable window", en_cnt, 200);
                chk(lane_idx == 8, "R7 lanes written", lane_idx, 8);
            end
            prev_en  = train_en_o;
            prev_req = rd_req_o;
        end
    end

    task automatic fill(input int kind);
        for (int i = 0; i < 8; i++) begin
            case (kind)
                0: begin ph_arr[i] = 10'h000; ofs_arr[i] = 10'h000; end
                1: begin ph_arr[i] = 10'h3FF; ofs_arr[i] = 10'h3FF; end
                2: begin ph_arr[i] = (i == 0) ? 10'h0FF : 10'h300; ofs_arr[i] = (i == 0) ? 10'h1E0 : 10'h01F; end
                default: begin ph_arr[i] = 10'($urandom); ofs_arr[i] = 10'($urandom); end
            endcase
        end
        exp_max = 0;
        for (int i = 0; i < 8; i++)
            if (exp_final(ph_arr[i], ofs_arr[i]) > exp_max) exp_max = exp_final(ph_arr[i], ofs_arr[i]);
    endtask

    task automatic run_pass(input int kind, input bit poke_busy);
        logic [2:0] cs;
        int guard;
        fill(kind);
        cs = 3'($urandom_range(0, 7));
        rd_acc = 0; en_cnt = 0; lane_idx = 0; done_cnt = 0;
        en_armed = 0; seed_seen = 0; first_rd = 1;
        @(negedge clk);
        quiet_ok_i = 1'b1;
        chip_sel_i = cs;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        chk(dimm_sel_o == (cs >> 1), "R2 dimm select", int'(dimm_sel_o), int'(cs >> 1));
        guard = 0;
        while (!done_o && guard < 3000) begin
            if (poke_busy && guard == 60) begin
                chip_sel_i = ~cs;
                start_i    = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, "R9 done reached", int'(done_o), 1);
        chk(dimm_sel_o == (cs >> 1), "R10 dimm held", int'(dimm_sel_o), int'(cs >> 1));
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R9 single pulse then idle",
            int'({done_o, busy_o}), 0);
        chk(done_cnt == 1, "R10 one done per pass", done_cnt, 1);
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R10 no restart", int'(busy_o), 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !train_en_o && !rd_req_o && !seed_go_o,
            "R9 reset idle", int'({busy_o, done_o, train_en_o, rd_req_o, seed_go_o}), 0);

        // R1: start refused while refresh/ZQ not reported off
        quiet_ok_i = 1'b0;
        start_i    = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (busy_o || seed_go_o || rd_req_o || train_en_o)
                chk(1'b0, "R1 start blocked", int'({busy_o, seed_go_o, rd_req_o}), 0);
        end
        start_i = 1'b0;
        chk(!busy_o && !rd_req_o, "R1 start blocked", int'({busy_o, rd_req_o}), 0);

        run_pass(0, 1'b0);   // all zero lanes: every lane = 0x20
        run_pass(1, 1'b0);   // all ones: ceiling 0x2FF, masked bits ignored
        run_pass(2, 1'b0);   // largest value in lane 0 only
        run_pass(3, 1'b1);   // random lanes, start poked while busy
        for (int r = 0; r < 8; r++) run_pass(3, (r % 3) == 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule